// File: doc/BRIEF.md
# Endpoint Interrupt Masking and DMA Gating

This block sits beside one endpoint of a USB device controller. It stores that endpoint's enable bits, and it masks the endpoint's event levels with them. From the masked sources it produces one registered interrupt request. It also passes or withholds the endpoint's DMA request. The events come from logic outside the block: received data, transmit completion, short packets, high-bandwidth MDATA/DATAx arrivals and the error conditions. The block receives them as levels that stay high until their owner clears them. The busy-bank and TX-ready sources are derived inside the block from bank occupancy, the endpoint direction and the TX-ready flag.

When the DMA-block bit is set, any enabled source that fires cuts off DMA, whether or not the interrupt is routed further up. Sources split into two classes. A packet-class source fires with a new bank packet. It lets a transfer already in progress finish and then refuses the next request. An immediate-class source is an error not tied to a packet. It drops the request in the same cycle, even in the middle of a transfer.

The gate is a three-state machine:
- GATE_OPEN passes requests.
- GATE_DRAIN holds a running transfer's request until the DMA engine reports it idle.
- GATE_BLOCKED withholds every request.

The transitions are:
- OPEN to DRAIN on a packet-class hit while busy.
- OPEN to BLOCKED on an immediate-class hit, or on a packet-class hit while idle.
- DRAIN to BLOCKED on an immediate-class hit, or when the transfer ends.
- DRAIN or BLOCKED back to OPEN once no enabled source is active with the block bit set.

A USB bus reset returns the machine to OPEN.

Top module: `ep_irq_dma_ctl`

## Requirements
- R1: A hardware reset or a USB bus reset clears every enable bit. The one exception is the endpoint-on bit, which resets to 1 when parameter EP_INDEX is 0 and to 0 otherwise. After the reset, no source raises the interrupt, and on endpoint 0 the DMA request follows dma_want_i.
- R2: A write pulse en_we_i loads en_wdata_i into the enable register. Bit 0 is endpoint-on, bit 1 is DMA-block, and bit 2+k enables source k. The source indices are: 0 received data, 1 TX-ready, 2 transmit complete, 3 short packet, 4 busy bank, 5 MDATA, 6 DATAx, 7 overflow error, 8 flow error, 9 CRC/transaction-count error, 10 flush error.
- R3: irq_o is a register. It is high in the cycle after any source that is both active and enabled while endpoint-on is 1, and low otherwise. A disabled source never raises it.
- R4: On an OUT endpoint (dir_in_i=0), the busy-bank source is active when banks_busy_i equals NBANKS. On an IN endpoint (dir_in_i=1), it is active when banks_busy_i is 0.
- R5: The TX-ready source is active while txrdy_flag_i is low and at least one bank is free (banks_busy_i < NBANKS), in either direction.
- R6: The MDATA and DATAx sources count only on OUT endpoints. With dir_in_i=1 they never raise the interrupt.
- R7: With the DMA-block bit clear, dma_req_o equals dma_want_i while endpoint-on is 1, even while enabled sources fire.
- R8: With DMA-block set, a packet-class hit (sources 0 to 6) arriving while dma_busy_i is 1 keeps dma_req_o equal to dma_want_i until dma_busy_i falls. From then on dma_req_o stays 0.
- R9: With DMA-block set, a packet-class hit while dma_busy_i is 0 forces dma_req_o to 0 in the same cycle.
- R10: With DMA-block set, an immediate-class hit (sources 7 to 10) forces dma_req_o to 0 in the same cycle, even while dma_busy_i is 1.
- R11: Once the hit is removed, the request is released by the second clock edge. The hit can be removed by clearing the DMA-block bit, by clearing the source's enable, or by the source going inactive.
- R12: With endpoint-on 0, dma_req_o is 0 and irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| usb_rst_i | input | 1 | USB bus reset, synchronous |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 13 | Enable register write value |
| dir_in_i | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| banks_busy_i | input | CNT_W | Number of occupied banks |
| txrdy_flag_i | input | 1 | TX-ready flag level |
| rx_rdy_i | input | 1 | Received-data event level |
| tx_done_i | input | 1 | Transmit-complete event level |
| short_i | input | 1 | Short-packet event level |
| mdata_i | input | 1 | MDATA packet received |
| datax_i | input | 1 | DATA0/1/2 packet received |
| ovfl_err_i | input | 1 | Overflow error level |
| flow_err_i | input | 1 | Isochronous flow error level |
| crc_err_i | input | 1 | CRC or transaction-count error level |
| flush_err_i | input | 1 | Bank flush error level |
| dma_want_i | input | 1 | DMA request from the bank logic |
| dma_busy_i | input | 1 | DMA transfer in progress |
| irq_o | output | 1 | Registered endpoint interrupt request |
| dma_req_o | output | 1 | Gated DMA request |

## Verification
Some relations are checked by the assertions on every cycle:
- a masked hit turns into irq_o one edge later;
- an immediate-class hit with the block bit set leaves no request;
- GATE_BLOCKED never passes a request;
- GATE_DRAIN keeps a request alive while the transfer runs;
- a disabled endpoint has no request;
- a bus reset restores the enable register.

Other behaviour is shown only by the bench's sweeps:
- the mapping of each enable bit to its source, and the class of each source;
- the direction-dependent busy-bank decode over every occupancy count;
- the TX-ready decode over every flag and occupancy count;
- the direction filter on MDATA/DATAx;
- the release of the request after each of the three ways of removing a hit.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

    localparam int NUM_SRC = 11;
    localparam int EN_W    = NUM_SRC + 2;

    localparam int BIT_EP_ON = 0;
    localparam int BIT_DMA_BLOCK = 1;
    localparam int BIT_SRC0 = 2;

    localparam int SRC_RXRDY = 0;
    localparam int SRC_TXRDY = 1;
    localparam int SRC_TXDONE = 2;
    localparam int SRC_SHORT = 3;
    localparam int SRC_BUSY = 4;
    localparam int SRC_MDATA = 5;
    localparam int SRC_DATAX = 6;
    localparam int SRC_OVFL = 7;
    localparam int SRC_FLOW = 8;
    localparam int SRC_CRC = 9;
    localparam int SRC_FLUSH = 10;

    localparam int NUM_PKT_SRC = 7;

    typedef enum logic [1:0] {
        GATE_OPEN    = 2'd0,
        GATE_DRAIN   = 2'd1,
        GATE_BLOCKED = 2'd2
    } gate_state_t;

endpackage

// File: rtl/ep_irq_en_regs.sv
module ep_irq_en_regs #(
    parameter int EP_INDEX = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          usb_rst_i,
    input  logic                          en_we_i,
    input  logic [ep_irq_pkg::EN_W-1:0]   en_wdata_i,
    output logic [ep_irq_pkg::EN_W-1:0]   en_q
);
    import ep_irq_pkg::*;

    localparam logic [EN_W-1:0] EN_RST = (EP_INDEX == 0) ? EN_W'(1) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= EN_RST;
        end else if (usb_rst_i) begin
            en_q <= EN_RST;
        end else if (en_we_i) begin
            en_q <= en_wdata_i;
        end
    end

endmodule

// File: rtl/ep_irq_src.sv
module ep_irq_src #(
    parameter int NBANKS = 2,
    parameter int CNT_W  = $clog2(NBANKS + 1)
) (
    input  logic [ep_irq_pkg::EN_W-1:0] en_q,
    input  logic                        dir_in_i,
    input  logic [CNT_W-1:0]            banks_busy_i,
    input  logic                        txrdy_flag_i,
    input  logic                        rx_rdy_i,
    input  logic                        tx_done_i,
    input  logic                        short_i,
    input  logic                        mdata_i,
    input  logic                        datax_i,
    input  logic                        ovfl_err_i,
    input  logic                        flow_err_i,
    input  logic                        crc_err_i,
    input  logic                        flush_err_i,
    output logic                        pkt_hit,
    output logic                        imm_hit,
    output logic                        any_hit
);
    import ep_irq_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NBANKS);

    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] masked;
    logic               all_full;
    logic               all_free;

    always_comb begin
        all_full = (banks_busy_i == FULL_CNT);
        all_free = (banks_busy_i == '0);
        raw = '0;
        raw[SRC_RXRDY]  = rx_rdy_i;
        raw[SRC_TXRDY]  = !txrdy_flag_i && !all_full;
        raw[SRC_TXDONE] = tx_done_i;
        raw[SRC_SHORT]  = short_i;
        raw[SRC_BUSY]   = dir_in_i ? all_free : all_full;
        raw[SRC_MDATA]  = mdata_i && !dir_in_i;
        raw[SRC_DATAX]  = datax_i && !dir_in_i;
        raw[SRC_OVFL]   = ovfl_err_i;
        raw[SRC_FLOW]   = flow_err_i;
        raw[SRC_CRC]    = crc_err_i;
        raw[SRC_FLUSH]  = flush_err_i;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_mask
            assign masked[k] = raw[k] && en_q[BIT_SRC0 + k] && en_q[BIT_EP_ON];
        end
    endgenerate

    assign pkt_hit = |masked[NUM_PKT_SRC-1:0];
    assign imm_hit = |masked[NUM_SRC-1:NUM_PKT_SRC];
    assign any_hit = pkt_hit || imm_hit;

endmodule

// File: rtl/ep_irq_dma_gate.sv
module ep_irq_dma_gate (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    usb_rst_i,
    input  logic                    ep_on,
    input  logic                    dma_block,
    input  logic                    pkt_hit,
    input  logic                    imm_hit,
    input  logic                    dma_want_i,
    input  logic                    dma_busy_i,
    output ep_irq_pkg::gate_state_t state,
    output logic                    dma_req_o
);
    import ep_irq_pkg::*;

    gate_state_t next_state;
    logic        cut_pkt;
    logic        cut_imm;

    assign cut_pkt = dma_block && pkt_hit;
    assign cut_imm = dma_block && imm_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GATE_OPEN;
        end else if (usb_rst_i) begin
            state <= GATE_OPEN;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        next_state = state;
        dma_req_o  = 1'b0;
        unique case (state)
            GATE_OPEN: begin
                dma_req_o = dma_want_i && !cut_imm && !(cut_pkt && !dma_busy_i);
                if (cut_imm) begin
                    next_state = GATE_BLOCKED;
                end else if (cut_pkt) begin
                    next_state = dma_busy_i ? GATE_DRAIN : GATE_BLOCKED;
                end
            end
            GATE_DRAIN: begin
                dma_req_o = dma_want_i && dma_busy_i && !cut_imm;
                if (!cut_pkt && !cut_imm) begin
                    next_state = GATE_OPEN;
                end else if (cut_imm || !dma_busy_i) begin
                    next_state = GATE_BLOCKED;
                end
            end
            GATE_BLOCKED: begin
                dma_req_o = 1'b0;
                if (!cut_pkt && !cut_imm) begin
                    next_state = GATE_OPEN;
                end
            end
            default: begin
                next_state = GATE_OPEN;
            end
        endcase
        dma_req_o = dma_req_o && ep_on;
    end

endmodule

// File: rtl/ep_irq_dma_ctl.sv
module ep_irq_dma_ctl #(
    parameter int EP_INDEX = 0,
    parameter int NBANKS   = 2,
    parameter int CNT_W    = $clog2(NBANKS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        usb_rst_i,
    input  logic                        en_we_i,
    input  logic [ep_irq_pkg::EN_W-1:0] en_wdata_i,
    input  logic                        dir_in_i,
    input  logic [CNT_W-1:0]            banks_busy_i,
    input  logic                        txrdy_flag_i,
    input  logic                        rx_rdy_i,
    input  logic                        tx_done_i,
    input  logic                        short_i,
    input  logic                        mdata_i,
    input  logic                        datax_i,
    input  logic                        ovfl_err_i,
    input  logic                        flow_err_i,
    input  logic                        crc_err_i,
    input  logic                        flush_err_i,
    input  logic                        dma_want_i,
    input  logic                        dma_busy_i,
    output logic                        irq_o,
    output logic                        dma_req_o
);
    import ep_irq_pkg::*;

    logic [EN_W-1:0] en_q;
    logic            pkt_hit;
    logic            imm_hit;
    logic            any_hit;
    gate_state_t     state;

    ep_irq_en_regs #(.EP_INDEX(EP_INDEX)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .usb_rst_i  (usb_rst_i),
        .en_we_i    (en_we_i),
        .en_wdata_i (en_wdata_i),
        .en_q       (en_q)
    );

    ep_irq_src #(.NBANKS(NBANKS), .CNT_W(CNT_W)) u_src (
        .en_q         (en_q),
        .dir_in_i     (dir_in_i),
        .banks_busy_i (banks_busy_i),
        .txrdy_flag_i (txrdy_flag_i),
        .rx_rdy_i     (rx_rdy_i),
        .tx_done_i    (tx_done_i),
        .short_i      (short_i),
        .mdata_i      (mdata_i),
        .datax_i      (datax_i),
        .ovfl_err_i   (ovfl_err_i),
        .flow_err_i   (flow_err_i),
        .crc_err_i    (crc_err_i),
        .flush_err_i  (flush_err_i),
        .pkt_hit      (pkt_hit),
        .imm_hit      (imm_hit),
        .any_hit      (any_hit)
    );

    ep_irq_dma_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .usb_rst_i  (usb_rst_i),
        .ep_on      (en_q[BIT_EP_ON]),
        .dma_block  (en_q[BIT_DMA_BLOCK]),
        .pkt_hit    (pkt_hit),
        .imm_hit    (imm_hit),
        .dma_want_i (dma_want_i),
        .dma_busy_i (dma_busy_i),
        .state      (state),
        .dma_req_o  (dma_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (usb_rst_i) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_hit;
        end
    end

endmodule

// File: rtl/ep_irq_dma_chk.sv
module ep_irq_dma_chk #(
    parameter int EP_INDEX = 0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        usb_rst_i,
    input logic [ep_irq_pkg::EN_W-1:0] en_q,
    input logic                        any_hit,
    input logic                        imm_hit,
    input ep_irq_pkg::gate_state_t     state,
    input logic                        dma_want_i,
    input logic                        dma_busy_i,
    input logic                        irq_o,
    input logic                        dma_req_o
);
    import ep_irq_pkg::*;

    // R1
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rst_i |=> (en_q[EN_W-1:1] == '0) && (en_q[BIT_EP_ON] == (EP_INDEX == 0)));

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !usb_rst_i) |=> irq_o);

    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> !irq_o);

    // R10
    imm_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[BIT_DMA_BLOCK] && imm_hit) |-> !dma_req_o);

    // R8
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_DRAIN && dma_busy_i && dma_want_i && !imm_hit && en_q[BIT_EP_ON]) |-> dma_req_o);

    // R8
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_BLOCKED) |-> !dma_req_o);

    // R12
    ep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[BIT_EP_ON] |-> !dma_req_o);

    // R7
    no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[BIT_DMA_BLOCK] && en_q[BIT_EP_ON] && state == GATE_OPEN) |-> (dma_req_o == dma_want_i));

endmodule

bind ep_irq_dma_ctl ep_irq_dma_chk #(.EP_INDEX(EP_INDEX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .usb_rst_i  (usb_rst_i),
    .en_q       (en_q),
    .any_hit    (any_hit),
    .imm_hit    (imm_hit),
    .state      (state),
    .dma_want_i (dma_want_i),
    .dma_busy_i (dma_busy_i),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o)
);

// File: tb/ep_irq_dma_ctl_tb.sv
module ep_irq_dma_ctl_tb;
    import ep_irq_pkg::*;

    localparam int NB = 2;
    localparam int CW = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usb_rst = 1'b0;
    logic en_we = 1'b0;
    logic [EN_W-1:0] en_wdata = '0;
    logic dir_in = 1'b0;
    logic [CW-1:0] busy_cnt = CW'(1);
    logic txrdy_flag = 1'b1;
    logic rx_rdy = 0, tx_done = 0, short_p = 0, mdata = 0, datax = 0;
    logic ovfl = 0, flow = 0, crc = 0, flush = 0;
    logic want = 1'b0, dbusy = 1'b0;
    logic irq, dreq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ep_irq_dma_ctl #(.EP_INDEX(0), .NBANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .usb_rst_i(usb_rst),
        .en_we_i(en_we), .en_wdata_i(en_wdata),
        .dir_in_i(dir_in), .banks_busy_i(busy_cnt), .txrdy_flag_i(txrdy_flag),
        .rx_rdy_i(rx_rdy), .tx_done_i(tx_done), .short_i(short_p),
        .mdata_i(mdata), .datax_i(datax), .ovfl_err_i(ovfl),
        .flow_err_i(flow), .crc_err_i(crc), .flush_err_i(flush),
        .dma_want_i(want), .dma_busy_i(dbusy),
        .irq_o(irq), .dma_req_o(dreq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_en(logic [EN_W-1:0] v);
        en_wdata = v;
        en_we = 1'b1;
        tick();
        en_we = 1'b0;
    endtask

    function automatic logic [EN_W-1:0] src_bit(int k);
        return EN_W'(1) << (BIT_SRC0 + k);
    endfunction

    task automatic set_src(int k, logic on);
        case (k)
            0: rx_rdy = on;
            1: txrdy_flag = !on;
            2: tx_done = on;
            3: short_p = on;
            4: busy_cnt = on ? CW'(NB) : CW'(1);
            5: mdata = on;
            6: datax = on;
            7: ovfl = on;
            8: flow = on;
            9: crc = on;
            default: flush = on;
        endcase
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: after reset, endpoint 0 is on, everything else masked
        want = 1'b1;
        rx_rdy = 1'b1;
        flow = 1'b1;
        #1;
        check("R1 reset dma_req", dreq, 1'b1);
        tick();
        check("R1 reset irq", irq, 1'b0);
        rx_rdy = 1'b0;
        flow = 1'b0;

        // R2 R3 R8 R9 R10 R11: sweep each source alone with DMA-block set
        for (int k = 0; k < NUM_SRC; k++) begin
            logic is_pkt;
            is_pkt = (k < NUM_PKT_SRC);
            write_en(EN_W'(3) | src_bit(k));
            want = 1'b1;
            dbusy = 1'b1;
            set_src(k, 1'b1);
            #1;
            check(is_pkt ? "R8 pkt hit while busy keeps req" : "R10 imm hit cuts req at once",
                  dreq, is_pkt);
            tick();
            check("R3 irq after masked hit", irq, 1'b1);
            check(is_pkt ? "R8 drain holds req" : "R10 stays cut", dreq, is_pkt);
            dbusy = 1'b0;
            #1;
            check("R8 req ends with transfer", dreq, 1'b0);
            tick();
            check("R8 blocked after drain", dreq, 1'b0);
            set_src(k, 1'b0);
            tick();
            tick();
            check("R11 release on source clear", dreq, 1'b1);
            check("R3 irq drops", irq, 1'b0);
        end

        // R9: packet hit with no transfer running cuts at once
        write_en(EN_W'(3) | src_bit(SRC_SHORT));
        dbusy = 1'b0;
        short_p = 1'b1;
        #1;
        check("R9 pkt hit idle cuts", dreq, 1'b0);
        tick();
        check("R9 stays cut", dreq, 1'b0);
        // R11: release by clearing block bit
        write_en(EN_W'(1) | src_bit(SRC_SHORT));
        tick();
        check("R11 release on block bit clear", dreq, 1'b1);
        check("R7 irq still fires without block", irq, 1'b1);
        short_p = 1'b0;

        // R11: release by clearing the source enable
        write_en(EN_W'(3) | src_bit(SRC_CRC));
        crc = 1'b1;
        #1;
        check("R10 crc cut", dreq, 1'b0);
        tick();
        write_en(EN_W'(3));
        tick();
        check("R11 release on enable clear", dreq, 1'b1);
        check("R3 disabled crc no irq", irq, 1'b0);
        crc = 1'b0;

        // R3 R2: enables off, each source active -> no irq, no gating
        write_en(EN_W'(3));
        for (int k = 0; k < NUM_SRC; k++) begin
            set_src(k, 1'b1);
            #1;
            check("R2 masked source no gating", dreq, 1'b1);
            tick();
            check("R3 masked source no irq", irq, 1'b0);
            set_src(k, 1'b0);
        end

        // R7: all sources enabled, block clear
        write_en({{NUM_SRC{1'b1}}, 2'b01});
        for (int k = 0; k < NUM_SRC; k++) begin
            set_src(k, 1'b1);
            for (int b = 0; b < 2; b++) begin
                dbusy = b[0];
                #1;
                check("R7 no block req follows want", dreq, 1'b1);
            end
            tick();
            check("R7 irq fires", irq, 1'b1);
            set_src(k, 1'b0);
        end
        dbusy = 1'b0;
        tick();

        // R4: busy-bank decode
        write_en(EN_W'(1) | src_bit(SRC_BUSY));
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c <= NB; c++) begin
                dir_in = d[0];
                busy_cnt = CW'(c);
                tick();
                check("R4 busy bank", irq, (d == 1) ? (c == 0) : (c == NB));
            end
        end
        dir_in = 1'b0;
        busy_cnt = CW'(1);

        // R5: TX-ready decode
        write_en(EN_W'(1) | src_bit(SRC_TXRDY));
        for (int d = 0; d < 2; d++) begin
            for (int f = 0; f < 2; f++) begin
                for (int c = 0; c <= NB; c++) begin
                    dir_in = d[0];
                    txrdy_flag = f[0];
                    busy_cnt = CW'(c);
                    tick();
                    check("R5 txrdy level", irq, (f == 0) && (c < NB));
                end
            end
        end
        dir_in = 1'b0;
        txrdy_flag = 1'b1;
        busy_cnt = CW'(1);

        // R6: MDATA/DATAx only on OUT
        write_en(EN_W'(1) | src_bit(SRC_MDATA) | src_bit(SRC_DATAX));
        for (int d = 0; d < 2; d++) begin
            for (int s = 1; s < 4; s++) begin
                dir_in = d[0];
                mdata = s[0];
                datax = s[1];
                tick();
                check("R6 mdata/datax direction", irq, d == 0);
            end
        end
        mdata = 1'b0;
        datax = 1'b0;
        dir_in = 1'b0;

        // R12: endpoint off
        write_en({{NUM_SRC{1'b1}}, 2'b10});
        rx_rdy = 1'b1;
        flow = 1'b1;
        want = 1'b1;
        #1;
        check("R12 ep off no dma", dreq, 1'b0);
        tick();
        check("R12 ep off no irq", irq, 1'b0);

        // R1: USB bus reset mid-run clears written enables
        write_en({{NUM_SRC{1'b1}}, 2'b11});
        tick();
        check("R1 pre-reset irq", irq, 1'b1);
        usb_rst = 1'b1;
        tick();
        usb_rst = 1'b0;
        check("R1 bus reset irq clear", irq, 1'b0);
        #1;
        check("R1 bus reset ep on, no block", dreq, 1'b1);
        tick();
        check("R1 bus reset sources masked", irq, 1'b0);
        rx_rdy = 1'b0;
        flow = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule